// File: doc/BRIEF.md
# Auxiliary-Channel Request Sequencer

This block runs one request on a display link's auxiliary side channel. Software loads a four-byte request header, and for writes the payload, into a command FIFO. It does this through a single data register and then sets a start bit. The block streams the queued bytes out, one per handshake, on a byte-wide valid/ready port toward a link-layer encoder. It then waits for the reply stream from the link side.

The first reply byte is a reply code. For a read, the bytes after it are stored in a reply buffer. Software reads that buffer back through the same data register: it rewinds the pointer, throws away one dummy word, and then takes one byte per read. The outcome is latched in a status register whose bits clear when written with 1. Masked status drives a level interrupt.

A reply timer guards against a silent link. Writing zero to the transfer-control register cancels a request that is still in flight. A soft reset bit in the control register clears every pointer and all status. Line coding, the analog side and retry policy belong to other blocks and to software.

Top module: `aux_xact_ctrl`

Register offsets on `reg_addr`:

| Offset | Register | Contents |
|---|---|---|
| 0 | CTRL | bit0 enable, bit1 soft reset |
| 1 | XFER | bit0 start, bit1 I2C mode |
| 2 | DATA | write: byte in [7:0], bit31 index flag, bit30 read flag. Read: reply data |
| 3 | STATUS | 7 status bits, write 1 to clear |
| 4 | INTEN | 7 interrupt-enable bits |
| 5 | TMO | timeout limit in cycles |

## Requirements
- R1: The command FIFO holds 144 bytes. A push beyond that is dropped and marks the FIFO overflowed. A start after an overflow is refused: STATUS bit4 sets, no byte is sent, and the overflow clears only on an index-flagged push.
- R2: The request goes out in this byte order:
  - byte0 = {3'b0, read flag in bit4, address[19:16]}
  - byte1 = address[15:8]
  - byte2 = address[7:0]
  - byte3 = length-1

  Each byte stays on tx_data with tx_valid high until tx_ready accepts it.
- R3: A read request sends exactly the four header bytes. A write request sends the header followed by its payload bytes, in the order they were pushed. The block checks the byte count against the length field at start.
- R4: Native requests (XFER bit1 = 0) carry at most 16 data bytes; I2C-mode requests carry at most 128. A start with a larger length is refused: STATUS bit4 sets, start reads 0 and tx_valid stays low.
- R5: Each DATA write without bit30 pushes byte [7:0] at the FIFO index and advances the index. When bit31 is set, the index returns to 0 before the byte is stored.
- R6: Writing XFER with bit0 = 1 starts exactly one request. XFER bit0 reads 1 while the request runs and 0 once it ends.
- R7: Reply readback works as follows:
  - A DATA write with both bit31 and bit30 set rewinds the reply pointer.
  - The next DATA read returns 0.
  - Each read after that returns the next stored reply byte in bits [15:8], with the other bits zero.
- R8: The first reply byte is the reply code, and the transfer ends on the byte with rx_last:
  - 0x00 (ACK): sets done (bit0). A read instead sets bit4 when the number of data bytes differs from the requested length.
  - 0x01 (native NACK) or 0x02 (native DEFER): sets bit3.
  - 0x04 (I2C NACK): sets bit5.
  - 0x08 (I2C DEFER): sets bit6.
  - Any other code: sets bit1.
- R9: The reply timer counts cycles without an incoming reply byte, starting when the last request byte is accepted. After TMO cycles, STATUS bit2 sets and the block returns to idle. TMO resets to 1000.
- R10: Writing XFER with bit0 = 0 during a request stops it at once. tx_valid drops, start reads 0, and no status bit sets.
- R11: While CTRL bit1 is set, the FIFO index, the reply pointer, the sequencer and all status bits clear. A new header can then be pushed from index 0 without the index flag.
- R12: While CTRL bit0 is 0, a start write is ignored (start reads 0) and tx_valid stays low.
- R13: Writing 1 to a STATUS bit clears it. irq is high exactly when some STATUS bit is set together with the same INTEN bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances reply pointer on DATA) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| tx_valid | output | 1 | Request byte available |
| tx_data | output | 8 | Request byte |
| tx_ready | input | 1 | Link side accepts request byte |
| rx_valid | input | 1 | Reply byte present |
| rx_data | input | 8 | Reply byte |
| rx_last | input | 1 | Marks final reply byte |
| irq | output | 1 | Masked status interrupt |

## Verification
The assertions assume that software never writes a register while a request byte is waiting for tx_ready. They also assume that reply bytes arrive only after the whole request has been accepted. The stimulus holds to this because each transaction runs strictly in sequence: push, start, drain the outbound stream, then drive the reply. Register accesses happen only before the start or after the reply ends. The one deliberate exception is the cancel case, where the write is made while the stream is active but is itself the point of the test.

// File: rtl/aux_xact_pkg.sv
package aux_xact_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_RESP = 2'd2
    } state_e;

    localparam int NSTS = 7;

    localparam int S_DONE  = 0;
    localparam int S_ADDR  = 1;
    localparam int S_TMO   = 2;
    localparam int S_NAT   = 3;
    localparam int S_WCNT  = 4;
    localparam int S_INACK = 5;
    localparam int S_IDEF  = 6;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_XFER  = 3'd1;
    localparam logic [2:0] A_DATA  = 3'd2;
    localparam logic [2:0] A_STS   = 3'd3;
    localparam logic [2:0] A_INTEN = 3'd4;
    localparam logic [2:0] A_TMO   = 3'd5;

endpackage

// File: rtl/aux_byte_ram.sv
module aux_byte_ram #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int MEM_N = 1 << AW;

    logic [7:0] mem [MEM_N];

    always_ff @(posedge clk) begin
        if (we && (waddr < AW'(DEPTH))) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = (raddr < AW'(DEPTH)) ? mem[raddr] : 8'h00;

endmodule

// File: rtl/aux_reply_timer.sv
module aux_reply_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run && (cnt_q != '1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q >= limit);

endmodule

// File: rtl/aux_xact_ctrl.sv
module aux_xact_ctrl
    import aux_xact_pkg::*;
#(
    parameter int CMD_DEPTH  = 144,
    parameter int NATIVE_MAX = 16,
    parameter int I2C_MAX    = 128,
    parameter int TMO_W      = 16,
    parameter int TMO_INIT   = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    input  logic        tx_ready,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    output logic        irq
);
    localparam int CIDX_W = $clog2(CMD_DEPTH + 1);
    localparam int RDEPTH = I2C_MAX;
    localparam int RP_W   = $clog2(RDEPTH + 2);
    localparam int LEN_W  = 9;

    typedef struct packed {
        state_e            st;
        logic              en;
        logic              rst;
        logic              go;
        logic              i2c;
        logic [CIDX_W-1:0] wr_idx;
        logic              ovf;
        logic              rd_flag;
        logic [7:0]        len_m1;
        logic [CIDX_W-1:0] snd_idx;
        logic              first;
        logic [7:0]        code;
        logic [RP_W-1:0]   rx_cnt;
        logic [RP_W-1:0]   rd_ptr;
        logic [NSTS-1:0]   sts;
        logic [NSTS-1:0]   inten;
        logic [TMO_W-1:0]  tmo;
    } regs_t;

    regs_t r_q, r_d;

    logic [NSTS-1:0]   sts_set;
    logic              cmd_we;
    logic [CIDX_W-1:0] cmd_wa;
    logic [7:0]        cmd_wd;
    logic [7:0]        cmd_rd;
    logic              rpl_we;
    logic [RP_W-1:0]   rpl_wa;
    logic [7:0]        rpl_rd;
    logic [RP_W-1:0]   rpl_ra;
    logic              tmr_clr;
    logic              tmr_exp;
    logic [LEN_W-1:0]  req_len;
    logic [LEN_W-1:0]  fin_cnt;
    logic [LEN_W-1:0]  fifo_cnt;
    logic [LEN_W-1:0]  len_max;
    logic [7:0]        fin_code;
    logic              req_ok;
    logic [CIDX_W-1:0] push_idx;
    logic              cancel;
    logic              abort;

    aux_byte_ram #(.DEPTH(CMD_DEPTH), .AW(CIDX_W)) u_cmd_ram (
        .clk   (clk),
        .we    (cmd_we),
        .waddr (cmd_wa),
        .wdata (cmd_wd),
        .raddr (r_q.snd_idx),
        .rdata (cmd_rd)
    );

    aux_byte_ram #(.DEPTH(RDEPTH), .AW(RP_W)) u_rpl_ram (
        .clk   (clk),
        .we    (rpl_we),
        .waddr (rpl_wa),
        .wdata (rx_data),
        .raddr (rpl_ra),
        .rdata (rpl_rd)
    );

    aux_reply_timer #(.W(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .run     (r_q.st == ST_RESP),
        .limit   (r_q.tmo),
        .expired (tmr_exp)
    );

    always_comb begin
        r_d      = r_q;
        sts_set  = '0;
        cmd_we   = 1'b0;
        cmd_wa   = r_q.wr_idx;
        cmd_wd   = reg_wdata[7:0];
        rpl_we   = 1'b0;
        rpl_wa   = r_q.rx_cnt;
        tmr_clr  = 1'b0;
        cancel   = 1'b0;
        abort    = !r_q.en && (r_q.st != ST_IDLE);
        req_len  = {1'b0, r_q.len_m1} + 1'b1;
        fifo_cnt = LEN_W'(r_q.wr_idx);
        len_max  = reg_wdata[1] ? LEN_W'(I2C_MAX) : LEN_W'(NATIVE_MAX);
        fin_code = r_q.first ? rx_data : r_q.code;
        fin_cnt  = r_q.first ? '0 : (LEN_W'(r_q.rx_cnt) + 1'b1);
        push_idx = reg_wdata[31] ? '0 : r_q.wr_idx;
        req_ok   = !r_q.ovf && (fifo_cnt >= LEN_W'(4)) && (req_len <= len_max)
                   && (r_q.rd_flag ? (fifo_cnt == LEN_W'(4))
                                   : (fifo_cnt == req_len + LEN_W'(4)));

        // transaction sequencer
        if (abort) begin
            r_d.st = ST_IDLE;
            r_d.go = 1'b0;
        end else begin
            case (r_q.st)
                ST_SEND: begin
                    if (tx_ready) begin
                        if (r_q.snd_idx == r_q.wr_idx - 1'b1) begin
                            r_d.st     = ST_RESP;
                            r_d.first  = 1'b1;
                            r_d.rx_cnt = '0;
                            tmr_clr    = 1'b1;
                        end else begin
                            r_d.snd_idx = r_q.snd_idx + 1'b1;
                        end
                    end
                end
                ST_RESP: begin
                    if (rx_valid) begin
                        tmr_clr = 1'b1;
                        if (r_q.first) begin
                            r_d.code  = rx_data;
                            r_d.first = 1'b0;
                        end else begin
                            rpl_we = (r_q.rx_cnt < RP_W'(RDEPTH));
                            if (r_q.rx_cnt != '1) begin
                                r_d.rx_cnt = r_q.rx_cnt + 1'b1;
                            end
                        end
                        if (rx_last) begin
                            r_d.st = ST_IDLE;
                            r_d.go = 1'b0;
                            case (fin_code)
                                8'h00: begin
                                    if (r_q.rd_flag && (fin_cnt != req_len)) begin
                                        sts_set[S_WCNT] = 1'b1;
                                    end else begin
                                        sts_set[S_DONE] = 1'b1;
                                    end
                                end
                                8'h01, 8'h02: sts_set[S_NAT]   = 1'b1;
                                8'h04:        sts_set[S_INACK] = 1'b1;
                                8'h08:        sts_set[S_IDEF]  = 1'b1;
                                default:      sts_set[S_ADDR]  = 1'b1;
                            endcase
                        end
                    end else if (tmr_exp) begin
                        sts_set[S_TMO] = 1'b1;
                        r_d.st         = ST_IDLE;
                        r_d.go         = 1'b0;
                    end
                end
                default: ;
            endcase
        end

        // reply readback pointer
        if (reg_rd && (reg_addr == A_DATA) && (r_q.rd_ptr != '1)) begin
            r_d.rd_ptr = r_q.rd_ptr + 1'b1;
        end

        // register writes
        if (reg_wr) begin
            case (reg_addr)
                A_CTRL: begin
                    r_d.en  = reg_wdata[0];
                    r_d.rst = reg_wdata[1];
                end
                A_XFER: begin
                    if (!reg_wdata[0]) begin
                        cancel = (r_q.st != ST_IDLE);
                        r_d.go = 1'b0;
                        r_d.st = ST_IDLE;
                    end else if (r_q.en && (r_q.st == ST_IDLE)) begin
                        r_d.i2c = reg_wdata[1];
                        if (req_ok) begin
                            r_d.go      = 1'b1;
                            r_d.st      = ST_SEND;
                            r_d.snd_idx = '0;
                        end else begin
                            sts_set[S_WCNT] = 1'b1;
                        end
                    end
                end
                A_DATA: begin
                    if (reg_wdata[31] && reg_wdata[30]) begin
                        r_d.rd_ptr = '0;
                    end else begin
                        if (reg_wdata[31]) begin
                            r_d.ovf = 1'b0;
                        end
                        if (push_idx < CIDX_W'(CMD_DEPTH)) begin
                            cmd_we     = 1'b1;
                            cmd_wa     = push_idx;
                            r_d.wr_idx = push_idx + 1'b1;
                            if (push_idx == CIDX_W'(0)) begin
                                r_d.rd_flag = reg_wdata[4];
                            end
                            if (push_idx == CIDX_W'(3)) begin
                                r_d.len_m1 = reg_wdata[7:0];
                            end
                        end else begin
                            r_d.ovf = 1'b1;
                        end
                    end
                end
                A_STS:   r_d.sts   = r_q.sts & ~reg_wdata[NSTS-1:0];
                A_INTEN: r_d.inten = reg_wdata[NSTS-1:0];
                A_TMO:   r_d.tmo   = reg_wdata[TMO_W-1:0];
                default: ;
            endcase
        end

        r_d.sts = r_d.sts | (cancel ? '0 : sts_set);

        // soft reset dominates everything but configuration
        if (r_q.rst) begin
            r_d.st      = ST_IDLE;
            r_d.go      = 1'b0;
            r_d.wr_idx  = '0;
            r_d.ovf     = 1'b0;
            r_d.snd_idx = '0;
            r_d.first   = 1'b0;
            r_d.rx_cnt  = '0;
            r_d.rd_ptr  = '0;
            r_d.sts     = '0;
            cmd_we      = 1'b0;
            rpl_we      = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= ST_IDLE;
            r_q.tmo <= TMO_W'(TMO_INIT);
        end else begin
            r_q <= r_d;
        end
    end

    assign rpl_ra   = r_q.rd_ptr - 1'b1;
    assign tx_valid = (r_q.st == ST_SEND);
    assign tx_data  = cmd_rd;
    assign irq      = |(r_q.sts & r_q.inten);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL:  reg_rdata = {30'd0, r_q.rst, r_q.en};
            A_XFER:  reg_rdata = {30'd0, r_q.i2c, r_q.go};
            A_DATA:  reg_rdata = (r_q.rd_ptr == '0) ? 32'd0 : {16'd0, rpl_rd, 8'd0};
            A_STS:   reg_rdata = 32'(r_q.sts);
            A_INTEN: reg_rdata = 32'(r_q.inten);
            A_TMO:   reg_rdata = 32'(r_q.tmo);
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/aux_xact_ctrl_chk.sv
module aux_xact_ctrl_chk #(
    parameter int CMD_DEPTH = 144,
    parameter int NSTS_P    = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_data,
    input logic              ctl_en,
    input logic              ctl_rst,
    input logic [NSTS_P-1:0] sts,
    input logic              irq
);
    logic [15:0] burst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            burst_q <= '0;
        end else if (!tx_valid) begin
            burst_q <= '0;
        end else if (tx_ready) begin
            burst_q <= burst_q + 1'b1;
        end
    end

    AST_BURST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        burst_q <= 16'(CMD_DEPTH));                                          // R1

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !reg_wr) |=> (tx_valid && $stable(tx_data))); // R2

    AST_DONE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts[0]) |-> ((sts[NSTS_P-1:1] & ~$past(sts[NSTS_P-1:1])) == '0)); // R8

    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rst |=> ((sts == '0) && !tx_valid));                               // R11

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_en && !$past(ctl_en)) |-> !tx_valid);                            // R12

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (sts != '0));                                                  // R13

endmodule

bind aux_xact_ctrl aux_xact_ctrl_chk #(
    .CMD_DEPTH (CMD_DEPTH),
    .NSTS_P    (aux_xact_pkg::NSTS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .ctl_en   (r_q.en),
    .ctl_rst  (r_q.rst),
    .sts      (r_q.sts),
    .irq      (irq)
);

// File: tb/aux_xact_ctrl_tb.sv
module aux_xact_ctrl_tb;
    localparam logic [2:0] A_CTRL = 3'd0, A_XFER = 3'd1, A_DATA = 3'd2;
    localparam logic [2:0] A_STS = 3'd3, A_INTEN = 3'd4, A_TMO = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_valid, tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] req [0:199];
    int         req_n;
    logic [7:0] got [0:199];
    int         got_n;
    logic [7:0] rep [0:199];
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    aux_xact_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .irq(irq)
    );

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic chk(bit ok, string r, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    // expected status from the reply-code table of R8
    function automatic logic [6:0] exp_sts(logic [7:0] code, bit rdq, int len, int nrep);
        case (code)
            8'h00:        return (rdq && nrep != len) ? 7'h10 : 7'h01;
            8'h01, 8'h02: return 7'h08;
            8'h04:        return 7'h20;
            8'h08:        return 7'h40;
            default:      return 7'h02;
        endcase
    endfunction

    task automatic build(bit rdq, logic [19:0] addr, int len);
        req[0] = {3'b000, rdq, addr[19:16]};
        req[1] = addr[15:8];
        req[2] = addr[7:0];
        req[3] = 8'(len - 1);
        req_n = 4;
        if (!rdq) begin
            for (int i = 0; i < len; i++) begin
                req[4 + i] = 8'($urandom);
            end
            req_n = 4 + len;
        end
    endtask

    task automatic push_all(bit idx_flag);
        for (int i = 0; i < req_n; i++) begin
            wr(A_DATA, {((i == 0) && idx_flag), 23'd0, req[i]});
        end
    endtask

    task automatic collect_tx(int n);
        int k = 0;
        int guard = 0;
        while (k < n && guard < 5000) begin
            @(negedge clk);
            tx_ready = ($urandom % 4) != 0;
            #1;
            if (tx_valid && tx_ready) begin
                got[k] = tx_data;
                k++;
            end
            guard++;
        end
        if (k == n) begin
            @(posedge clk); #1;
        end
        tx_ready = 1'b0;
        got_n = k;
    endtask

    task automatic send_reply(logic [7:0] code, int nrep);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = code; rx_last = (nrep == 0);
        @(posedge clk); #1;
        for (int i = 0; i < nrep; i++) begin
            rep[i] = 8'($urandom);
            @(negedge clk);
            rx_valid = 1'b1; rx_data = rep[i]; rx_last = (i == nrep - 1);
            @(posedge clk); #1;
        end
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic watch_idle(int n, string r);
        bit seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            if (tx_valid) seen = 1;
        end
        chk(!seen, r, 32'(seen), 0);
    endtask

    task automatic run_xact(bit i2c, bit rdq, logic [19:0] addr, int len,
                            logic [7:0] code, int nrep, bit clr);
        logic [6:0] es;
        logic [31:0] d;
        build(rdq, addr, len);
        wr(A_DATA, 32'h0000_00a5);               // stale bytes before index reset (R5)
        push_all(1'b1);
        wr(A_XFER, {30'd0, i2c, 1'b1});
        rd(A_XFER, d);
        chk(d[0] == 1'b1, "R6 start reads 1 while running", d, 1);
        collect_tx(req_n);
        chk(got_n == req_n, rdq ? "R3 read sends header only" : "R3 write byte count",
            32'(got_n), 32'(req_n));
        for (int i = 0; i < req_n && i < got_n; i++) begin
            chk(got[i] == req[i], (i < 4) ? "R2 header byte" : "R3 payload byte", got[i], req[i]);
        end
        send_reply(code, nrep);
        es = exp_sts(code, rdq, len, nrep);
        rd(A_STS, d);
        chk(d[6:0] == es, "R8 status after reply", d, 32'(es));
        rd(A_XFER, d);
        chk(d[0] == 1'b0, "R6 start clears at end", d, 0);
        if (rdq && es == 7'h01) begin
            wr(A_DATA, 32'hc000_0000);
            rd(A_DATA, d);
            chk(d == 32'd0, "R7 dummy first word", d, 0);
            for (int i = 0; i < len; i++) begin
                rd(A_DATA, d);
                chk(d == {16'd0, rep[i], 8'd0}, "R7 reply byte in [15:8]", d, {16'd0, rep[i], 8'd0});
            end
        end
        if (clr) begin
            wr(A_STS, 32'h7f);
            rd(A_STS, d);
            chk(d == 32'd0, "R13 write-one clears status", d, 0);
        end
    endtask

    task automatic refused(bit i2c, int len, string r);
        logic [31:0] d;
        build(1'b0, 20'h12345, len);
        push_all(1'b1);
        wr(A_XFER, {30'd0, i2c, 1'b1});
        rd(A_STS, d);
        chk(d == 32'h10, r, d, 32'h10);
        rd(A_XFER, d);
        chk(d[0] == 1'b0, r, d, 0);
        watch_idle(8, r);
        wr(A_STS, 32'h7f);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual running expected finished");
        report();
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5eed_1234));
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state
        rd(A_STS, d);   chk(d == 0, "R13 status zero after reset", d, 0);
        rd(A_XFER, d);  chk(d == 0, "R6 start zero after reset", d, 0);
        rd(A_TMO, d);   chk(d == 1000, "R9 timeout limit reset value", d, 1000);
        chk(!tx_valid, "R12 idle after reset", 32'(tx_valid), 0);
        chk(!irq, "R13 irq low after reset", 32'(irq), 0);

        // disabled: start ignored
        build(1'b1, 20'h00abc, 4);
        push_all(1'b1);
        wr(A_XFER, 32'h1);
        rd(A_XFER, d);  chk(d[0] == 1'b0, "R12 start ignored when disabled", d, 0);
        watch_idle(10, "R12 no output when disabled");

        wr(A_CTRL, 32'h1);
        wr(A_INTEN, 32'h7f);

        // boundaries of length limits
        run_xact(1'b0, 1'b0, 20'hfffff, 16, 8'h00, 0, 1'b1);
        run_xact(1'b1, 1'b0, 20'h00001, 128, 8'h00, 0, 1'b1);
        run_xact(1'b0, 1'b1, 20'h80000, 16, 8'h00, 16, 1'b1);
        refused(1'b0, 17, "R4 native over 16 refused");
        refused(1'b1, 129, "R4 I2C over 128 refused");

        // FIFO overflow
        build(1'b0, 20'h0f0f0, 128);
        push_all(1'b1);
        for (int i = 0; i < 16; i++) wr(A_DATA, 32'h0000_0011);
        wr(A_XFER, 32'h3);
        rd(A_STS, d);   chk(d == 32'h10, "R1 overflowed FIFO refused", d, 32'h10);
        watch_idle(6, "R1 no bytes after overflow");
        wr(A_STS, 32'h7f);

        // reply codes
        run_xact(1'b0, 1'b0, 20'h00100, 2, 8'h01, 0, 1'b1);
        run_xact(1'b0, 1'b1, 20'h00200, 3, 8'h02, 0, 1'b1);
        run_xact(1'b1, 1'b1, 20'h00050, 1, 8'h04, 0, 1'b1);
        run_xact(1'b1, 1'b0, 20'h00050, 5, 8'h08, 0, 1'b1);
        run_xact(1'b0, 1'b1, 20'h00300, 4, 8'h03, 0, 1'b1);
        run_xact(1'b0, 1'b1, 20'h00400, 6, 8'h00, 5, 1'b1);

        // timeout
        wr(A_TMO, 32'd20);
        build(1'b1, 20'h01234, 4);
        push_all(1'b1);
        wr(A_XFER, 32'h1);
        collect_tx(4);
        repeat (5) @(posedge clk);
        rd(A_STS, d);   chk(d == 0, "R9 no timeout before limit", d, 0);
        repeat (25) @(posedge clk);
        rd(A_STS, d);   chk(d == 32'h04, "R9 timeout status", d, 32'h04);
        rd(A_XFER, d);  chk(d[0] == 1'b0, "R9 idle after timeout", d, 0);
        wr(A_STS, 32'h7f);
        wr(A_TMO, 32'd1000);

        // cancel mid-stream
        build(1'b0, 20'h04444, 10);
        push_all(1'b1);
        wr(A_XFER, 32'h1);
        collect_tx(3);
        wr(A_XFER, 32'h0);
        rd(A_XFER, d);  chk(d[0] == 1'b0, "R10 cancel clears start", d, 0);
        rd(A_STS, d);   chk(d == 0, "R10 cancel sets no status", d, 0);
        watch_idle(6, "R10 stream stops on cancel");

        // interrupt masking and soft reset
        run_xact(1'b0, 1'b0, 20'h00010, 1, 8'h01, 0, 1'b0);
        @(negedge clk); #1;
        chk(irq, "R13 irq with enabled status", 32'(irq), 1);
        wr(A_INTEN, 32'h04);
        @(negedge clk); #1;
        chk(!irq, "R13 irq masked", 32'(irq), 0);
        wr(A_INTEN, 32'h7f);
        wr(A_DATA, 32'h0000_0077);
        wr(A_CTRL, 32'h3);
        wr(A_CTRL, 32'h1);
        rd(A_STS, d);   chk(d == 0, "R11 soft reset clears status", d, 0);
        chk(!irq, "R11 irq low after soft reset", 32'(irq), 0);
        build(1'b1, 20'h9a5c3, 2);
        push_all(1'b0);
        wr(A_XFER, 32'h1);
        collect_tx(4);
        for (int i = 0; i < 4; i++) begin
            chk(got[i] == req[i], "R11 header from index 0 after reset", got[i], req[i]);
        end
        send_reply(8'h00, 2);
        rd(A_STS, d);   chk(d == 32'h01, "R11 transfer after reset", d, 1);
        wr(A_STS, 32'h7f);

        // random traffic
        for (int t = 0; t < 24; t++) begin
            bit i2c = 1'($urandom);
            bit rdq = 1'($urandom);
            int len = 1 + int'($urandom % (i2c ? 128 : 16));
            logic [7:0] codes [8] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h04, 8'h08, 8'h02};
            logic [7:0] code = codes[$urandom % 8];
            int nrep = 0;
            if (rdq && code == 8'h00) nrep = (($urandom % 5) == 0) ? len - 1 : len;
            run_xact(i2c, rdq, 20'($urandom), len, code, nrep, 1'b1);
        end

        report();
    end

endmodule